// File: doc/BRIEF.md
# Synchronous Serial Clocked-Word Receiver

This block is the master end of a synchronous serial link to an absolute position sensor. On a start request it drives a burst of clock pulses of programmable length, reads the slave's data line once per pulse, and builds a word from the bits, most significant bit first. The clock output rests high. Each bit period is a low phase followed by a high phase, and each phase lasts a programmable number of system clocks. The slave changes its data after each rising clock edge. The master samples the line in the last system clock of each high phase.

The block also checks the data line for timing faults. During the first low phase the line must still be high, because a low there means the slave answered early. After the last bit, the slave must hold the line low for the whole monoflop interval, because a high there means it released too soon. A word that saw either fault is discarded. A clean word is written into a receive FIFO at the end of the monoflop interval, and software reads it through a show-ahead read port. A sticky error flag and a sticky overflow flag share one write-one-to-clear control input. Status outputs report busy, FIFO empty and FIFO more than half full.

Top module: `ssi_master_rx`

## Requirements
- R1: After reset, sclk_o is 1, busy is 0, rx_err is 0, ovf is 0, fifo_empty is 1 and fifo_half is 0. sclk_o stays 1 whenever busy is 0.
- R2: A start pulse seen while idle runs word_len clock pulses (1 to 32). Each pulse is clk_div system clocks low, then clk_div system clocks high (clk_div at least 1). The data line is sampled in the last system clock of each high phase. The first sample is the most significant bit, and the word is right-aligned in rd_data with zeros above it.
- R3: busy is 1 from the clock after the accepted start until the monoflop interval of mono_time system clocks (at least 1) has ended. A start pulse while busy is 1 is ignored and is not queued.
- R4: A low data line in any system clock of the first low phase raises rx_err.
- R5: A high data line in any system clock of the monoflop interval raises rx_err.
- R6: A word is written into the FIFO at the end of the monoflop interval only if neither R4 nor R5 occurred during that transfer. A word with a fault is dropped.
- R7: rx_err stays set until a cycle with err_clr high and no new fault. A fault in the same cycle as err_clr keeps it set.
- R8: fifo_empty is 1 exactly when the FIFO holds no word. rd_data shows the oldest word, and rd_en removes it. rd_en while the FIFO is empty has no effect.
- R9: fifo_half is 1 exactly when the FIFO holds more than half of FIFO_DEPTH words (default depth 8, so 5 or more).
- R10: A clean word that completes while the FIFO is full is discarded and sets ovf. ovf is sticky and is cleared by err_clr. The FIFO contents are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one word transfer |
| word_len | input | 6 | Bits per word, 1 to 32 |
| clk_div | input | 8 | System clocks per clock phase, at least 1 |
| mono_time | input | 16 | Monoflop interval in system clocks, at least 1 |
| err_clr | input | 1 | Write-one-to-clear for rx_err and ovf |
| sclk_o | output | 1 | Serial clock to the slave, idles high |
| sdata_i | input | 1 | Serial data from the slave |
| rd_en | input | 1 | Pop the oldest FIFO word |
| rd_data | output | 32 | Oldest FIFO word (show-ahead) |
| busy | output | 1 | Transfer in progress |
| rx_err | output | 1 | Sticky timing error |
| ovf | output | 1 | Sticky FIFO overflow |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_half | output | 1 | FIFO holds more than half its depth |

## Verification
The assertions assume that sdata_i is already synchronous to clk and that word_len, clk_div and mono_time are in range and do not change while busy is 1. The bench sets all three configuration inputs before each start pulse and holds them until busy falls. It changes sdata_i only at falling edges of clk. It drives a new data bit only after it has seen sclk_o go high, and it lowers the line only after the last sampling cycle. Faults are injected on purpose in the first low phase and in the monoflop window.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_MONO = 2'd3
  } ssi_state_e;
endpackage

// File: rtl/ssi_seq.sv
module ssi_seq
  import ssi_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LW    = 6,
  parameter int DIVW  = 8,
  parameter int MONOW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LW-1:0]    word_len,
  input  logic [DIVW-1:0]  clk_div,
  input  logic [MONOW-1:0] mono_time,
  input  logic             sdata_i,
  output logic             sclk_o,
  output logic             busy,
  output logic [DW-1:0]    word,
  output logic             push,
  output logic             err_hit
);
  localparam int CW = (DIVW > MONOW) ? DIVW : MONOW;

  ssi_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] bits_q, bits_d;
  logic          first_q, first_d;
  logic          err_q, err_d;
  logic          sclk_q, sclk_d;
  logic [DW-1:0] shift_q, shift_d;
  logic [CW-1:0] div_m1, mono_m1;

  assign div_m1  = CW'(clk_div) - CW'(1);
  assign mono_m1 = CW'(mono_time) - CW'(1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bits_d  = bits_q;
    first_d = first_q;
    err_d   = err_q;
    shift_d = shift_q;
    push    = 1'b0;
    err_hit = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_LOW;
          cnt_d   = div_m1;
          bits_d  = word_len;
          first_d = 1'b1;
          err_d   = 1'b0;
          shift_d = '0;
        end
      end
      ST_LOW: begin
        err_hit = first_q && !sdata_i;
        if (err_hit) err_d = 1'b1;
        if (cnt_q == '0) begin
          state_d = ST_HIGH;
          cnt_d   = div_m1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_HIGH: begin
        if (cnt_q == '0) begin
          shift_d = {shift_q[DW-2:0], sdata_i};
          first_d = 1'b0;
          bits_d  = bits_q - LW'(1);
          if (bits_q == LW'(1)) begin
            state_d = ST_MONO;
            cnt_d   = mono_m1;
          end else begin
            state_d = ST_LOW;
            cnt_d   = div_m1;
          end
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_MONO: begin
        err_hit = sdata_i;
        if (err_hit) err_d = 1'b1;
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
          push    = !(err_q || sdata_i);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
    sclk_d = (state_d != ST_LOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bits_q  <= '0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
      sclk_q  <= 1'b1;
      shift_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bits_q  <= bits_d;
      first_q <= first_d;
      err_q   <= err_d;
      sclk_q  <= sclk_d;
      shift_q <= shift_d;
    end
  end

  assign sclk_o = sclk_q;
  assign busy   = (state_q != ST_IDLE);
  assign word   = shift_q;

  // R3
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MONO && cnt_q != '0 && start) |=> (state_q == ST_MONO));

  // R6
  push_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push |-> !err_q));
endmodule

// File: rtl/ssi_fifo.sv
module ssi_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full,
  output logic          half
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic          wr_ok, rd_ok;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == NW'(DEPTH));
  assign half  = (cnt_q > NW'(DEPTH / 2));
  assign wr_ok = wr && !full;
  assign rd_ok = rd && !empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (wr_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    if (rd_ok) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    if (wr_ok && !rd_ok) cnt_d = cnt_q + NW'(1);
    else if (rd_ok && !wr_ok) cnt_d = cnt_q - NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full && !rd) |=> full);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && empty && !wr) |=> empty);
endmodule

// File: rtl/ssi_master_rx.sv
module ssi_master_rx #(
  parameter int DW         = 32,
  parameter int LW         = 6,
  parameter int DIVW       = 8,
  parameter int MONOW      = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LW-1:0]    word_len,
  input  logic [DIVW-1:0]  clk_div,
  input  logic [MONOW-1:0] mono_time,
  input  logic             err_clr,
  output logic             sclk_o,
  input  logic             sdata_i,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  output logic             busy,
  output logic             rx_err,
  output logic             ovf,
  output logic             fifo_empty,
  output logic             fifo_half
);
  logic          rst_meta_q, rst_sync_q;
  logic          push, err_hit, fifo_full;
  logic [DW-1:0] word;
  logic          rx_err_d, ovf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ssi_seq #(.DW(DW), .LW(LW), .DIVW(DIVW), .MONOW(MONOW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start     (start),
    .word_len  (word_len),
    .clk_div   (clk_div),
    .mono_time (mono_time),
    .sdata_i   (sdata_i),
    .sclk_o    (sclk_o),
    .busy      (busy),
    .word      (word),
    .push      (push),
    .err_hit   (err_hit)
  );

  ssi_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .wr    (push),
    .wdata (word),
    .rd    (rd_en),
    .rdata (rd_data),
    .empty (fifo_empty),
    .full  (fifo_full),
    .half  (fifo_half)
  );

  always_comb begin
    rx_err_d = rx_err;
    ovf_d    = ovf;
    if (err_clr) begin
      rx_err_d = 1'b0;
      ovf_d    = 1'b0;
    end
    if (err_hit) rx_err_d = 1'b1;
    if (push && fifo_full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      rx_err <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      rx_err <= rx_err_d;
      ovf    <= ovf_d;
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!busy |-> sclk_o));

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (err_hit |=> rx_err));

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (rx_err && !err_clr) |=> rx_err);

  // R3
  push_end_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (push |=> !busy));
endmodule

// File: tb/ssi_master_rx_test.sv
module ssi_master_rx_test;
  logic        clk, rst_n, start, err_clr, sdata_i, rd_en;
  logic [5:0]  word_len;
  logic [7:0]  clk_div;
  logic [15:0] mono_time;
  logic        sclk_o, busy, rx_err, ovf, fifo_empty, fifo_half;
  logic [31:0] rd_data;
  int          n_run = 0;
  int          n_fail = 0;

  ssi_master_rx uut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_len(word_len),
    .clk_div(clk_div), .mono_time(mono_time), .err_clr(err_clr),
    .sclk_o(sclk_o), .sdata_i(sdata_i), .rd_en(rd_en), .rd_data(rd_data),
    .busy(busy), .rx_err(rx_err), .ovf(ovf), .fifo_empty(fifo_empty),
    .fifo_half(fifo_half)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {mode[1:0], len[7:0], data[31:0]}; mode 0 clean, 1 early low, 2 monoflop high, 3 start while busy
  localparam logic [41:0] VEC [7] = '{
    {2'd0, 8'd8,  32'h0000_00A5},
    {2'd0, 8'd1,  32'h0000_0001},
    {2'd0, 8'd32, 32'hDEAD_BEEF},
    {2'd1, 8'd12, 32'h0000_05A3},
    {2'd2, 8'd16, 32'h0000_1234},
    {2'd3, 8'd5,  32'h0000_0015},
    {2'd0, 8'd7,  32'h0000_0040}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int len, input logic [31:0] data, input int mode);
    sdata_i = 1'b1;
    word_len = 6'(len);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R3 busy after start", 32'(busy), 32'd1);
    for (int k = 0; k < len; k++) begin
      while (sclk_o != 1'b0) @(negedge clk);
      if (k == 0 && mode == 1) sdata_i = 1'b0;
      while (sclk_o != 1'b1) @(negedge clk);
      sdata_i = data[len-1-k];
    end
    repeat (int'(clk_div)) @(negedge clk);
    sdata_i = (mode == 2) ? 1'b1 : 1'b0;
    if (mode == 3) start = 1'b1;
    @(negedge clk);
    sdata_i = 1'b0;
    start = 1'b0;
    while (busy) @(negedge clk);
    sdata_i = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R3 idle after monoflop", 32'(busy), 32'd0);
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic clear_err();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; err_clr = 1'b0; sdata_i = 1'b1; rd_en = 1'b0;
    word_len = 6'd8; clk_div = 8'd2; mono_time = 16'd5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(sclk_o == 1'b1, "R1 sclk idle", 32'(sclk_o), 32'd1);
    check(busy == 1'b0, "R1 busy", 32'(busy), 32'd0);
    check(rx_err == 1'b0 && ovf == 1'b0, "R1 flags", {30'd0, rx_err, ovf}, 32'd0);
    check(fifo_empty == 1'b1 && fifo_half == 1'b0, "R1 fifo", {30'd0, fifo_empty, fifo_half}, 32'd2);

    for (int i = 0; i < 7; i++) begin
      int          m;
      int          l;
      logic [31:0] d;
      m = int'(VEC[i][41:40]);
      l = int'(VEC[i][39:32]);
      d = VEC[i][31:0];
      xfer(l, d, m);
      if (m == 1 || m == 2) begin
        check(rx_err == 1'b1, "R4 R5 fault flagged", 32'(rx_err), 32'd1);
        check(fifo_empty == 1'b1, "R6 faulty word dropped", 32'(fifo_empty), 32'd1);
        clear_err();
        check(rx_err == 1'b0, "R7 cleared", 32'(rx_err), 32'd0);
      end else begin
        check(rx_err == 1'b0, "R6 clean no error", 32'(rx_err), 32'd0);
        check(fifo_empty == 1'b0 && rd_data == d, "R2 word value", rd_data, d);
        pop();
        check(fifo_empty == 1'b1, "R8 empty after pop", 32'(fifo_empty), 32'd1);
      end
    end

    // R8 read while empty has no effect
    pop();
    check(fifo_empty == 1'b1, "R8 read empty", 32'(fifo_empty), 32'd1);

    // R2 fastest corner: one-clock phases, one-clock monoflop
    clk_div = 8'd1; mono_time = 16'd1;
    xfer(3, 32'h5, 0);
    check(rx_err == 1'b0 && rd_data == 32'h5, "R2 minimum timing", rd_data, 32'h5);
    pop();

    // R4 with one-clock phases
    xfer(4, 32'hA, 1);
    check(rx_err == 1'b1 && fifo_empty == 1'b1, "R4 short phase fault", {30'd0, rx_err, fifo_empty}, 32'd3);

    // R7 fault coinciding with clear keeps flag set
    word_len = 6'd2;
    sdata_i = 1'b0;
    err_clr = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    err_clr = 1'b0;
    check(rx_err == 1'b1, "R7 set wins over clear", 32'(rx_err), 32'd1);
    sdata_i = 1'b1;
    while (busy) @(negedge clk);
    clear_err();

    // R9 and R10: fill the FIFO
    for (int i = 0; i < 9; i++) begin
      xfer(4, 32'(i), 0);
      if (i == 3) check(fifo_half == 1'b0, "R9 half at four", 32'(fifo_half), 32'd0);
      if (i == 4) check(fifo_half == 1'b1, "R9 half at five", 32'(fifo_half), 32'd1);
      if (i == 7) check(ovf == 1'b0, "R10 no overflow at full", 32'(ovf), 32'd0);
    end
    check(ovf == 1'b1, "R10 overflow set", 32'(ovf), 32'd1);
    for (int i = 0; i < 8; i++) begin
      check(fifo_empty == 1'b0 && rd_data == 32'(i), "R10 contents kept", rd_data, 32'(i));
      pop();
    end
    check(fifo_empty == 1'b1, "R10 ninth dropped", 32'(fifo_empty), 32'd1);
    clear_err();
    check(ovf == 1'b0, "R10 overflow cleared", 32'(ovf), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule